// File: doc/BRIEF.md
# Battery Charge Ledger with Capacity Learning

This block keeps the running record of a rechargeable battery's available charge and learns the battery's real full capacity over time. It takes count pulses that an upstream stage has already compensated for rate and temperature: charge, discharge and self-discharge. It also takes event inputs: a qualified valid charge, the first-empty voltage crossing, a below-freezing indication, a battery re-initialisation and the programmed full count.

The available-charge counter moves between zero and the learned capacity. A separate discharge tally measures how much charge came out since the battery was last full. The learned capacity takes the value of that tally only after an uninterrupted full-to-empty discharge. Several events disqualify a discharge: too much estimated self-discharge, a sustained valid charge part way through, or reaching empty while cold. A charge-cycle counter records how many valid charges have passed since the last capacity update and raises a capacity-inaccurate flag once that number grows large. A host can overwrite the available charge through a one-cycle write strobe.

Top module: `chg_ledger`

## Requirements
- R1: The available count `nac_o` rises by one per charge pulse but never above `lmd_o`. It falls by one per cycle with a discharge or self-discharge pulse (both together count as one step) but never below 0. A charge pulse in the same cycle as either decrement pulse leaves it unchanged.
- R2: The discharge tally `dcr_o` gains one in each cycle with a discharge pulse. A self-discharge pulse alone adds one only while `nac_o` is above 0. A cycle adds at most one.
- R3: While `nac_o` equals `lmd_o`, `dcr_o` is reloaded with 1 if that cycle carries a counting pulse and with 0 otherwise. `dcr_o` saturates at 0xFFFF.
- R4: The self-discharge tally `sdcr_o` counts self-discharge pulses while `nac_o` is above 0. It restarts like `dcr_o` while full and saturates at 4096.
- R5: The valid-discharge flag `vdq_o` sets on a discharge pulse while `nac_o` equals `lmd_o`.
- R6: `vdq_o` clears on a valid charge, on a first-empty event while `cold_i` is high, or one cycle after `sdcr_o` reaches 4096.
- R7: A valid charge, arriving while a first-empty event is latched and `vdq_o` is set, copies `dcr_o` into `lmd_o`, clamps `nac_o` to the new capacity, and clears `cyc_o` and `ci_o`.
- R8: `cyc_o` gains one per valid charge and saturates at 255. `ci_o` sets once `cyc_o` reaches 64.
- R9: When `nac_o*16 > lmd_o*15`, only the first valid charge is counted. Later valid charges are not counted until that comparison has been false for at least one cycle.
- R10: `init_i` loads `lmd_o` from `pfc_i`, sets `ci_o` and `brp_o`, and clears `cyc_o`, `vdq_o`, `dcr_o`, `sdcr_o` and the first-empty latch. `nac_o` becomes `pfc_i` if `preset_i` is high and 0 otherwise.
- R11: A host write (`wr_en_i`) sets `nac_o` to `wr_data_i`, clamped to `lmd_o`.
- R12: `brp_o` clears when a charge step brings `nac_o` up to `lmd_o`, or on a valid charge while a first-empty event is latched.
- R13: While `rst_ni` is low, all state is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Battery re-initialisation event |
| preset_i | input | 1 | Start full on re-initialisation |
| pfc_i | input | 16 | Programmed full count |
| chg_i | input | 1 | Compensated charge pulse |
| dsg_i | input | 1 | Compensated discharge pulse |
| sdsg_i | input | 1 | Self-discharge pulse |
| vchg_i | input | 1 | Valid charge detected |
| edv1_i | input | 1 | First-empty threshold crossed |
| cold_i | input | 1 | Temperature below 0 °C |
| wr_en_i | input | 1 | Host write strobe for available count |
| wr_data_i | input | 16 | Host write value |
| nac_o | output | 16 | Available charge count |
| dcr_o | output | 16 | Discharge tally since full |
| sdcr_o | output | 13 | Self-discharge tally since full |
| lmd_o | output | 16 | Learned capacity |
| cyc_o | output | 8 | Valid charges since last learning |
| vdq_o | output | 1 | Discharge still qualifies for learning |
| ci_o | output | 1 | Capacity inaccurate |
| brp_o | output | 1 | Battery replaced / re-initialised |

## Verification
The assertions check on every cycle that the available count never exceeds the learned capacity. They also check that opposing pulses leave the count stable, that the tallies and the cycle counter hold at their limits, that a cold first-empty event drops the qualification, and what a learning update and a re-initialisation leave behind. Only the bench scenarios can show the longer stories: a complete full-to-empty discharge followed by learning, a discharge disqualified by cold or by a mid-way charge, the high-charge gating of the cycle counter across a discharge below the 15/16 mark, the 4096 self-discharge limit, and the clamping of host writes and learned values.

// File: rtl/chg_ledger_pkg.sv
package chg_ledger_pkg;
  // true when cnt*16 > cap*15 (about 93.75 % of capacity)
  function automatic logic above_hi(input logic [15:0] cnt, input logic [15:0] cap);
    logic [19:0] lhs, rhs;
    lhs = {cnt, 4'b0000};
    rhs = {cap, 4'b0000} - {4'b0000, cap};
    return lhs > rhs;
  endfunction
endpackage

// File: rtl/chg_nac_cnt.sv
module chg_nac_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         preset_i,
  input  logic [W-1:0] pfc_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         chg_i,
  input  logic         dsg_i,
  input  logic         sdsg_i,
  input  logic [W-1:0] lmd_i,
  input  logic         upd_i,
  input  logic [W-1:0] upd_cap_i,
  output logic [W-1:0] nac_o,
  output logic         up_o,
  output logic         at_full_o,
  output logic         empty_o
);
  logic [W-1:0] nac_q, nac_d;
  logic down, up_ok, dn_ok;

  assign down  = dsg_i | sdsg_i;
  assign up_ok = chg_i & ~down & (nac_q < lmd_i);
  assign dn_ok = down & ~chg_i & (nac_q != '0);

  always_comb begin
    nac_d = nac_q;
    if (init_i)       nac_d = preset_i ? pfc_i : '0;
    else if (wr_en_i) nac_d = (wr_data_i > lmd_i) ? lmd_i : wr_data_i;
    else if (upd_i)   nac_d = (nac_q > upd_cap_i) ? upd_cap_i : nac_q;
    else if (up_ok)   nac_d = nac_q + 1'b1;
    else if (dn_ok)   nac_d = nac_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) nac_q <= '0;
    else         nac_q <= nac_d;

  assign nac_o     = nac_q;
  assign up_o      = up_ok & ~init_i & ~wr_en_i & ~upd_i;
  assign at_full_o = (nac_q == lmd_i);
  assign empty_o   = (nac_q == '0);

  // R1
  nac_le_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nac_q <= lmd_i);
  // R1
  cancel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_i && down && !init_i && !wr_en_i && !upd_i) |=> $stable(nac_q));
endmodule

// File: rtl/chg_dsg_track.sv
module chg_dsg_track #(
  parameter int W        = 16,
  parameter int SD_LIMIT = 4096,
  localparam int SD_W    = $clog2(SD_LIMIT + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            init_i,
  input  logic            dsg_i,
  input  logic            sdsg_i,
  input  logic            at_full_i,
  input  logic            empty_i,
  input  logic            vchg_i,
  input  logic            edv1_i,
  input  logic            cold_i,
  output logic [W-1:0]    dcr_o,
  output logic [SD_W-1:0] sdcr_o,
  output logic            vdq_o
);
  localparam logic [SD_W-1:0] SD_MAX = SD_W'(SD_LIMIT);

  logic [W-1:0]    dcr_q, dcr_d;
  logic [SD_W-1:0] sdcr_q, sdcr_d;
  logic            vdq_q, vdq_d;
  logic            dcr_inc, sd_inc;

  assign sd_inc  = sdsg_i & ~empty_i;
  assign dcr_inc = dsg_i | sd_inc;

  always_comb begin
    dcr_d  = dcr_q;
    sdcr_d = sdcr_q;
    vdq_d  = vdq_q;
    if (init_i) begin
      dcr_d  = '0;
      sdcr_d = '0;
      vdq_d  = 1'b0;
    end else begin
      if (at_full_i)                  dcr_d = W'(dcr_inc);
      else if (dcr_inc && dcr_q != '1) dcr_d = dcr_q + 1'b1;
      if (at_full_i)                        sdcr_d = SD_W'(sd_inc);
      else if (sd_inc && sdcr_q < SD_MAX)   sdcr_d = sdcr_q + 1'b1;
      if (vchg_i || (edv1_i && cold_i) || sdcr_q >= SD_MAX) vdq_d = 1'b0;
      else if (dsg_i && at_full_i)                          vdq_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      dcr_q  <= '0;
      sdcr_q <= '0;
      vdq_q  <= 1'b0;
    end else begin
      dcr_q  <= dcr_d;
      sdcr_q <= sdcr_d;
      vdq_q  <= vdq_d;
    end

  assign dcr_o  = dcr_q;
  assign sdcr_o = sdcr_q;
  assign vdq_o  = vdq_q;

  // R3
  dcr_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dcr_q == '1 && !init_i && !at_full_i) |=> dcr_q == '1);
  // R4
  sdcr_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdcr_q <= SD_MAX);
  // R6
  cold_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edv1_i && cold_i) |=> !vdq_q);
endmodule

// File: rtl/chg_cap_learn.sv
module chg_cap_learn #(
  parameter int W      = 16,
  parameter int CYC_W  = 8,
  parameter int CI_TH  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic [W-1:0]     pfc_i,
  input  logic             vchg_i,
  input  logic             edv1_i,
  input  logic             vdq_i,
  input  logic [W-1:0]     dcr_i,
  input  logic [W-1:0]     nac_i,
  input  logic             up_i,
  output logic             upd_o,
  output logic [W-1:0]     lmd_o,
  output logic [CYC_W-1:0] cyc_o,
  output logic             ci_o,
  output logic             brp_o
);
  import chg_ledger_pkg::*;

  logic [W-1:0]     lmd_q, lmd_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic ci_q, ci_d, brp_q, brp_d, edv_q, edv_d, lock_q, lock_d;
  logic hi, step, fill;

  assign hi    = above_hi(16'(nac_i), 16'(lmd_q));
  assign upd_o = vchg_i & edv_q & vdq_i;
  assign step  = vchg_i & ~(hi & lock_q) & (cyc_q != '1);
  assign fill  = up_i & (({1'b0, nac_i} + 1'b1) == {1'b0, lmd_q});

  always_comb begin
    lmd_d  = lmd_q;
    cyc_d  = cyc_q;
    ci_d   = ci_q;
    brp_d  = brp_q;
    edv_d  = edv_q;
    lock_d = lock_q;
    if (init_i) begin
      lmd_d  = pfc_i;
      cyc_d  = '0;
      ci_d   = 1'b1;
      brp_d  = 1'b1;
      edv_d  = 1'b0;
      lock_d = 1'b0;
    end else begin
      if (upd_o) begin
        lmd_d = dcr_i;
        cyc_d = '0;
        ci_d  = 1'b0;
      end else if (step) begin
        cyc_d = cyc_q + 1'b1;
        if (cyc_d >= CYC_W'(CI_TH)) ci_d = 1'b1;
      end
      if ((vchg_i && edv_q) || fill) brp_d = 1'b0;
      if (vchg_i)      edv_d = 1'b0;
      else if (edv1_i) edv_d = 1'b1;
      if (!hi)         lock_d = 1'b0;
      else if (vchg_i) lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      lmd_q  <= '0;
      cyc_q  <= '0;
      ci_q   <= 1'b0;
      brp_q  <= 1'b0;
      edv_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      lmd_q  <= lmd_d;
      cyc_q  <= cyc_d;
      ci_q   <= ci_d;
      brp_q  <= brp_d;
      edv_q  <= edv_d;
      lock_q <= lock_d;
    end

  assign lmd_o = lmd_q;
  assign cyc_o = cyc_q;
  assign ci_o  = ci_q;
  assign brp_o = brp_q;

  // R7
  learn_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o && !init_i) |=> (lmd_q == $past(dcr_i)) && (cyc_q == '0) && !ci_q);
  // R8
  cyc_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == '1 && !upd_o && !init_i) |=> cyc_q == '1);
  // R10
  init_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (lmd_q == $past(pfc_i)) && ci_q && brp_q && (cyc_q == '0));
endmodule

// File: rtl/chg_ledger.sv
module chg_ledger #(
  parameter int W        = 16,
  parameter int CYC_W    = 8,
  parameter int CI_TH    = 64,
  parameter int SD_LIMIT = 4096,
  localparam int SD_W    = $clog2(SD_LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             preset_i,
  input  logic [W-1:0]     pfc_i,
  input  logic             chg_i,
  input  logic             dsg_i,
  input  logic             sdsg_i,
  input  logic             vchg_i,
  input  logic             edv1_i,
  input  logic             cold_i,
  input  logic             wr_en_i,
  input  logic [W-1:0]     wr_data_i,
  output logic [W-1:0]     nac_o,
  output logic [W-1:0]     dcr_o,
  output logic [SD_W-1:0]  sdcr_o,
  output logic [W-1:0]     lmd_o,
  output logic [CYC_W-1:0] cyc_o,
  output logic             vdq_o,
  output logic             ci_o,
  output logic             brp_o
);
  logic up, at_full, empty, upd;

  chg_nac_cnt #(.W(W)) u_nac (
    .clk_i, .rst_ni, .init_i, .preset_i, .pfc_i, .wr_en_i, .wr_data_i,
    .chg_i, .dsg_i, .sdsg_i, .lmd_i(lmd_o), .upd_i(upd), .upd_cap_i(dcr_o),
    .nac_o, .up_o(up), .at_full_o(at_full), .empty_o(empty)
  );

  chg_dsg_track #(.W(W), .SD_LIMIT(SD_LIMIT)) u_dsg (
    .clk_i, .rst_ni, .init_i, .dsg_i, .sdsg_i, .at_full_i(at_full),
    .empty_i(empty), .vchg_i, .edv1_i, .cold_i, .dcr_o, .sdcr_o, .vdq_o
  );

  chg_cap_learn #(.W(W), .CYC_W(CYC_W), .CI_TH(CI_TH)) u_cap (
    .clk_i, .rst_ni, .init_i, .pfc_i, .vchg_i, .edv1_i, .vdq_i(vdq_o),
    .dcr_i(dcr_o), .nac_i(nac_o), .up_i(up), .upd_o(upd), .lmd_o, .cyc_o,
    .ci_o, .brp_o
  );
endmodule

// File: tb/tb_chg_ledger.sv
module tb_chg_ledger;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic init = 0, preset = 0, chg = 0, dsg = 0, sdsg = 0, vchg = 0, edv1 = 0, cold = 0, wr_en = 0;
  logic [15:0] pfc = '0, wr_data = '0;
  logic [15:0] nac, dcr, lmd;
  logic [12:0] sdcr;
  logic [7:0]  cyc;
  logic vdq, ci, brp;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chg_ledger dut (
    .clk_i(clk), .rst_ni, .init_i(init), .preset_i(preset), .pfc_i(pfc),
    .chg_i(chg), .dsg_i(dsg), .sdsg_i(sdsg), .vchg_i(vchg), .edv1_i(edv1),
    .cold_i(cold), .wr_en_i(wr_en), .wr_data_i(wr_data), .nac_o(nac),
    .dcr_o(dcr), .sdcr_o(sdcr), .lmd_o(lmd), .cyc_o(cyc), .vdq_o(vdq),
    .ci_o(ci), .brp_o(brp)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // v = {chg, dsg, sdsg, vchg, edv1}, held for n cycles
  task automatic drive(input logic [4:0] v, input int n);
    {chg, dsg, sdsg, vchg, edv1} = v;
    repeat (n) @(negedge clk);
    {chg, dsg, sdsg, vchg, edv1} = '0;
  endtask

  task automatic do_init(input int full, input logic pre);
    pfc = 16'(full); preset = pre; init = 1;
    @(negedge clk);
    init = 0;
  endtask

  task automatic host_wr(input int val);
    wr_data = 16'(val); wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R13", "nac", int'(nac), 0); chk("R13", "lmd", int'(lmd), 0);
    chk("R13", "ci", int'(ci), 0);   chk("R13", "brp", int'(brp), 0);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic t_init_fill;
    do_init(100, 0);
    chk("R10", "lmd", int'(lmd), 100); chk("R10", "nac", int'(nac), 0);
    chk("R10", "ci", int'(ci), 1);     chk("R10", "brp", int'(brp), 1);
    drive(5'b10000, 99);
    chk("R12", "brp before full", int'(brp), 1);
    drive(5'b10000, 6);
    chk("R1", "nac capped", int'(nac), 100);
    chk("R12", "brp after full", int'(brp), 0);
    chk("R3", "dcr at full", int'(dcr), 0);
  endtask

  task automatic t_discharge;
    drive(5'b01000, 1);
    chk("R5", "vdq", int'(vdq), 1); chk("R3", "dcr restart", int'(dcr), 1);
    drive(5'b01000, 9);
    drive(5'b00100, 5);
    chk("R1", "nac", int'(nac), 85); chk("R2", "dcr", int'(dcr), 15);
    chk("R4", "sdcr", int'(sdcr), 5);
    drive(5'b01100, 1);
    chk("R1", "dual dec nac", int'(nac), 84); chk("R2", "dual dec dcr", int'(dcr), 16);
    drive(5'b11000, 1);
    chk("R1", "cancel nac", int'(nac), 84); chk("R2", "cancel dcr", int'(dcr), 17);
    drive(5'b01000, 90);
    chk("R1", "nac floor", int'(nac), 0); chk("R2", "dcr", int'(dcr), 107);
    drive(5'b00100, 3);
    chk("R2", "sdsg at empty dcr", int'(dcr), 107);
    chk("R4", "sdsg at empty sdcr", int'(sdcr), 6);
  endtask

  task automatic t_learn;
    drive(5'b00001, 1);
    chk("R7", "lmd before", int'(lmd), 100);
    drive(5'b00010, 1);
    chk("R7", "lmd learned", int'(lmd), 107); chk("R7", "cyc", int'(cyc), 0);
    chk("R7", "ci", int'(ci), 0); chk("R6", "vdq", int'(vdq), 0);
  endtask

  task automatic t_cold_gate;
    drive(5'b10000, 107);
    drive(5'b01000, 1);
    chk("R5", "vdq", int'(vdq), 1);
    cold = 1;
    drive(5'b00001, 1);
    cold = 0;
    chk("R6", "cold vdq", int'(vdq), 0);
    drive(5'b00010, 1);
    chk("R7", "no learn", int'(lmd), 107); chk("R8", "cyc", int'(cyc), 1);
    drive(5'b00010, 1);
    chk("R9", "locked cyc", int'(cyc), 1);
    drive(5'b01000, 10);
    drive(5'b00010, 1);
    chk("R9", "unlocked cyc", int'(cyc), 2);
  endtask

  task automatic t_vdq_chg;
    drive(5'b10000, 11);
    drive(5'b01000, 1);
    chk("R5", "vdq", int'(vdq), 1);
    drive(5'b00010, 1);
    chk("R6", "vchg vdq", int'(vdq), 0); chk("R8", "cyc", int'(cyc), 3);
  endtask

  task automatic t_cycles;
    drive(5'b01000, 50);
    drive(5'b00010, 60);
    chk("R8", "cyc 63", int'(cyc), 63); chk("R8", "ci at 63", int'(ci), 0);
    drive(5'b00010, 1);
    chk("R8", "cyc 64", int'(cyc), 64); chk("R8", "ci at 64", int'(ci), 1);
    drive(5'b00010, 200);
    chk("R8", "cyc sat", int'(cyc), 255);
  endtask

  task automatic t_sdcr;
    do_init(5000, 1);
    chk("R10", "preset nac", int'(nac), 5000); chk("R10", "cyc", int'(cyc), 0);
    chk("R10", "ci", int'(ci), 1);
    drive(5'b01000, 1);
    drive(5'b00100, 4095);
    chk("R4", "sdcr 4095", int'(sdcr), 4095); chk("R6", "vdq kept", int'(vdq), 1);
    drive(5'b00100, 1);
    @(negedge clk);
    chk("R6", "sd limit vdq", int'(vdq), 0);
    drive(5'b00100, 3);
    chk("R4", "sdcr sat", int'(sdcr), 4096);
  endtask

  task automatic t_host;
    host_wr(6000);
    chk("R11", "clamped", int'(nac), 5000);
    host_wr(123);
    chk("R11", "written", int'(nac), 123);
  endtask

  task automatic t_clamp;
    do_init(200, 1);
    drive(5'b01000, 1);
    drive(5'b00001, 1);
    host_wr(150);
    chk("R5", "vdq", int'(vdq), 1);
    chk("R12", "brp before", int'(brp), 1);
    drive(5'b00010, 1);
    chk("R7", "lmd", int'(lmd), 1); chk("R7", "nac clamp", int'(nac), 1);
    chk("R12", "brp after", int'(brp), 0);
  endtask

  task automatic t_dcr_sat;
    do_init(100, 0);
    drive(5'b01000, 65534);
    chk("R3", "dcr 65534", int'(dcr), 65534);
    drive(5'b01000, 5);
    chk("R3", "dcr sat", int'(dcr), 65535); chk("R1", "nac", int'(nac), 0);
  endtask

  initial begin
    t_reset;
    t_init_fill;
    t_discharge;
    t_learn;
    t_cold_gate;
    t_vdq_chg;
    t_cycles;
    t_sdcr;
    t_host;
    t_clamp;
    t_dcr_sat;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule